// File: doc/BRIEF.md
# 8-bit ALU with status byte

This block is an 8-bit arithmetic and logic unit that keeps its own result register and an 8-bit status byte. Each cycle in which `go` is high, the unit applies the selected operation to the two operands. It then writes the result, the updated flags, or both, at the next rising clock edge. The operations are load, add, subtract, AND, inclusive OR, exclusive OR, compare, rotate right and rotate left. Three further codes write the status byte directly: overwrite it, set selected bits, or clear selected bits.

Two mode bits in the status byte steer the arithmetic. The with-carry bit decides whether the stored carry feeds add, subtract and the rotates. The compare-mode bit decides whether a compare treats the operands as unsigned or as two's complement. A spare storage bit is carried along untouched. The status layout is fixed:

| Bit | Meaning |
|-----|---------|
| 0 | carry |
| 1 | compare mode (1 means unsigned) |
| 2 | overflow |
| 3 | with-carry |
| 4 | spare |
| 5 | inter-digit carry |
| 7:6 | condition code |

Operation codes on `op` are:

| Code | Operation |
|------|-----------|
| 0 | load |
| 1 | add |
| 2 | subtract |
| 3 | AND |
| 4 | OR |
| 5 | XOR |
| 6 | compare |
| 7 | rotate right |
| 8 | rotate left |
| 9 | status write |
| 10 | status set |
| 11 | status clear |
| 12-15 | no operation |

Top module: `alu8_status`

## Requirements
- R1: After reset, and while reset is held, `result` and `status` are both 0.
- R2: Add (op 1) stores a+b+cin in `result`, where cin is status bit 0 when bit 3 is 1 and is 0 otherwise. The bit-8 carry out goes to status bit 0.
- R3: Subtract (op 2) stores a-b-borrow, where borrow is the inverse of status bit 0 when bit 3 is 1 and is 0 otherwise. Status bit 0 becomes 1 when no borrow out occurred.
- R4: Add and subtract write to status bit 5 the carry from bit 3 into bit 4. For subtract, this carry is taken from the sum a + ~b + (1-borrow).
- R5: Add and subtract set status bit 2 exactly when a two's-complement overflow occurs.
- R6: Load, add, subtract, logic ops and rotates set the condition code (bits 7:6) from the new result: 00 when it is zero, 10 when bit 7 is 1, 01 otherwise.
- R7: Load (op 0) stores b. AND, OR and XOR (ops 3, 4, 5) store a op b. Of the status bits, these change only the condition code.
- R8: Compare (op 6) leaves `result` unchanged. It sets the condition code to 01 for a>b, 10 for a<b and 00 for a==b. The comparison is unsigned when bit 1 is 1 and signed when bit 1 is 0. No other status bit changes.
- R9: With bit 3 clear, rotate right (op 7) and rotate left (op 8) do a plain 8-bit rotate of a. Carry, inter-digit carry and overflow hold their values.
- R10: With bit 3 set, rotates run through the carry as a 9-bit rotate, and carry receives the bit shifted out. Inter-digit carry receives the bit that crosses between bits 3 and 4: a[4] for right, a[3] for left. Overflow is set when bit 7 of the result differs from a[7].
- R11: Operations 0 to 8 never change status bits 1, 3 and 4.
- R12: Status write (op 9) loads b, status set (op 10) ORs b in, and status clear (op 11) clears the bits that are 1 in b. None of these changes `result`.
- R13: With `go` low, or with an op code of 12 to 15, neither `result` nor `status` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Apply `op` at the next edge |
| op | input | 4 | Operation code |
| a | input | 8 | First operand (the only operand for rotates) |
| b | input | 8 | Second operand, or mask for status codes |
| result | output | 8 | Registered result |
| status | output | 8 | Registered status byte |

## Verification
The assertions assume that `go`, `op`, `a` and `b` are stable and free of unknown values at every rising edge once reset is released. They also assume that reset is released away from a clock edge. The stimulus meets these conditions by changing every input only at the falling edge and by taking all values from defined constants or from `$urandom`. Every op code, including the unused codes, is reached with both settings of the with-carry and compare-mode bits. Directed steps cover the corner cases: carry and signed overflow on add, borrow on subtract, the signed and unsigned views of 0x80 against 0x01, equal compares, and rotates of 0x01 and 0x80.

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic [7:0]   status
);
  localparam int H = W / 2;

  logic [W-1:0] res_q, res_n;
  logic [7:0]   st_q, st_n;

  wire c_q  = st_q[0];
  wire unsg = st_q[1];
  wire wc   = st_q[3];
  wire sub  = (op == 4'd2);

  wire [W-1:0] b_eff = sub ? ~b : b;
  wire         cin   = wc ? c_q : sub;
  wire [W:0]   sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  wire [H:0]   nib   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
  wire         ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  wire [W-1:0] rr = {wc ? c_q : a[0], a[W-1:1]};
  wire [W-1:0] rl = {a[W-2:0], wc ? c_q : a[W-1]};

  wire gt = unsg ? (a > b) : ($signed(a) > $signed(b));
  wire lt = unsg ? (a < b) : ($signed(a) < $signed(b));

  function automatic logic [1:0] cc_of(input logic [W-1:0] v);
    if (v == '0) return 2'b00;
    if (v[W-1])  return 2'b10;
    return 2'b01;
  endfunction

  always_comb begin
    res_n = res_q;
    st_n  = st_q;
    if (go) begin
      unique case (op)
        4'd0: res_n = b;
        4'd1, 4'd2: begin
          res_n   = sum[W-1:0];
          st_n[0] = sum[W];
          st_n[2] = ovf;
          st_n[5] = nib[H];
        end
        4'd3: res_n = a & b;
        4'd4: res_n = a | b;
        4'd5: res_n = a ^ b;
        4'd6: st_n[7:6] = gt ? 2'b01 : (lt ? 2'b10 : 2'b00);
        4'd7: begin
          res_n = rr;
          if (wc) begin
            st_n[0] = a[0];
            st_n[5] = a[H];
            st_n[2] = rr[W-1] ^ a[W-1];
          end
        end
        4'd8: begin
          res_n = rl;
          if (wc) begin
            st_n[0] = a[W-1];
            st_n[5] = a[H-1];
            st_n[2] = rl[W-1] ^ a[W-1];
          end
        end
        4'd9:  st_n = b[7:0];
        4'd10: st_n = st_q | b[7:0];
        4'd11: st_n = st_q & ~b[7:0];
        default: ;
      endcase
      if (op <= 4'd8 && op != 4'd6) st_n[7:6] = cc_of(res_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      st_q  <= '0;
    end else begin
      res_q <= res_n;
      st_q  <= st_n;
    end
  end

  assign result = res_q;
  assign status = st_q;

  a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!go || op >= 4'd12) |=> ($stable(result) && $stable(status)));

  a_r11_modes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op <= 4'd8) |=> (status[4] == $past(status[4]) &&
                            status[3] == $past(status[3]) &&
                            status[1] == $past(status[1])));

  a_r8_compare_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 4'd6) |=> ($stable(result) && status[7:6] != 2'b11));

  a_r7_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op == 4'd3 || op == 4'd4 || op == 4'd5)) |=> $stable(status[5:0]));

  a_r2_plain_add: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 4'd1 && !status[3]) |=>
      ({status[0], result} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

  a_r12_status_ops_keep_result: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op >= 4'd9 && op <= 4'd11) |=> $stable(result));
endmodule

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic [7:0] result, status;

  int checks = 0;
  int errors = 0;
  int m_res = 0;
  int m_st = 0;

  alu8_status u_alu8_status (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op),
    .a(a), .b(b), .result(result), .status(status)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int ccv(int r);
    if (r == 0) return 0;
    if (r >= 128) return 2;
    return 1;
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int o, int g);
    if (!g || o >= 12) return "R13";
    case (o)
      0, 3, 4, 5: return "R7/R6/R11";
      1: return "R2/R4/R5/R6/R11";
      2: return "R3/R4/R5/R6/R11";
      6: return "R8/R11";
      7, 8: return "R9/R10/R6/R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(int g, int o, int x, int y);
    int c, wc, r, s, ci, cc;
    if (!g || o >= 12) return;
    c = m_st & 1;
    wc = (m_st >> 3) & 1;
    r = m_res;
    case (o)
      0: r = y;
      1: begin
        ci = wc ? c : 0;
        s = x + y + ci;
        r = s & 255;
        m_st = (m_st & ~8'h25) | (s >> 8) | (((((x & 15) + (y & 15) + ci) >> 4) & 1) << 5);
        if (((x ^ r) & (y ^ r) & 128) != 0) m_st |= 4;
      end
      2: begin
        ci = wc ? c : 1;
        s = x + (255 - y) + ci;
        r = s & 255;
        m_st = (m_st & ~8'h25) | (s >> 8) | (((((x & 15) + (15 - (y & 15)) + ci) >> 4) & 1) << 5);
        if (((x ^ y) & (x ^ r) & 128) != 0) m_st |= 4;
      end
      3: r = x & y;
      4: r = x | y;
      5: r = x ^ y;
      6: begin
        if ((m_st >> 1) & 1) cc = (x > y) ? 1 : (x < y) ? 2 : 0;
        else cc = (sgn(x) > sgn(y)) ? 1 : (sgn(x) < sgn(y)) ? 2 : 0;
        m_st = (m_st & 8'h3F) | (cc << 6);
      end
      7: begin
        r = (x >> 1) | ((wc ? c : (x & 1)) << 7);
        if (wc) begin
          m_st = (m_st & ~8'h25) | (x & 1) | (((x >> 4) & 1) << 5);
          if (((r ^ x) & 128) != 0) m_st |= 4;
        end
      end
      8: begin
        r = ((x << 1) & 255) | (wc ? c : (x >> 7));
        if (wc) begin
          m_st = (m_st & ~8'h25) | (x >> 7) | (((x >> 3) & 1) << 5);
          if (((r ^ x) & 128) != 0) m_st |= 4;
        end
      end
      9: m_st = y;
      10: m_st = m_st | y;
      default: m_st = m_st & ~y & 255;
    endcase
    if (o <= 8 && o != 6) m_st = (m_st & 8'h3F) | (ccv(r) << 6);
    m_res = r;
  endtask

  task automatic compare(string tag);
    checks++;
    if (result !== m_res[7:0] || status !== m_st[7:0]) begin
      errors++;
      $display("FAIL %s: result=%h status=%h expected result=%h status=%h",
               tag, result, status, m_res[7:0], m_st[7:0]);
    end
  endtask

  task automatic drive(int g, int o, int x, int y);
    go = g[0];
    op = o[3:0];
    a = x[7:0];
    b = y[7:0];
    model(g, o, x, y);
    @(negedge clk);
    compare(tag_of(o, g));
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    drive(1, 0, 0, 8'h7F);
    drive(1, 1, 8'h7F, 8'h01);
    drive(1, 1, 8'hFF, 8'h01);
    drive(1, 2, 8'h00, 8'h01);
    drive(1, 2, 8'h80, 8'h01);
    drive(1, 10, 0, 8'h08);
    drive(1, 1, 8'h0F, 8'h00);
    drive(1, 2, 8'h10, 8'h00);
    drive(1, 6, 8'h80, 8'h01);
    drive(1, 10, 0, 8'h02);
    drive(1, 6, 8'h80, 8'h01);
    drive(1, 6, 8'h33, 8'h33);
    drive(1, 7, 8'h01, 0);
    drive(1, 8, 8'h80, 0);
    drive(1, 11, 0, 8'h08);
    drive(1, 7, 8'h01, 0);
    drive(1, 8, 8'h80, 0);
    drive(0, 1, 8'h55, 8'h55);
    drive(1, 13, 8'h55, 8'h55);
    drive(1, 9, 0, 8'hFF);
    drive(1, 5, 8'hF0, 8'h0F);
    drive(1, 3, 8'hF0, 8'h0F);

    for (int i = 0; i < 4000; i++)
      drive(($urandom % 8) != 0, $urandom % 16, $urandom % 256, $urandom % 256);

    rst_n = 1'b0;
    m_res = 0;
    m_st = 0;
    @(negedge clk);
    compare("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule